// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox with Handshake Status

This block is a one-byte mailbox in each direction between an external host bus and an internal slave processor bus, of the kind used for keyboard-controller style links. The host deposits a byte in an inbound data register. The slave deposits a byte in an outbound data register. An 8-bit status register tells each side whether a byte is waiting. The status register also records whether the last inbound byte was a command or plain data, and it carries a few general-purpose bits that the slave sets for the host to read.

Both buses are synchronous and share one clock. Each bus has a chip select and separate read and write strobes. Read data is combinational from the addressed register. The flag side effects of an access take place at the rising clock edge on which the strobe is sampled. The inbound-full flag, gated by an enable bit the slave controls, drives a level interrupt toward the slave.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset every register is 0: inbound data, outbound data, status and interrupt enable. The interrupt output is low.
- R2: A host write (host_cs and host_wr) at either host address loads host_wdata into the inbound register and sets the inbound-full flag, status bit 1. The slave reads the inbound register at slave address 0.
- R3: On every host write, status bit 3 takes the value of host_addr: 0 marks data and 1 marks a command.
- R4: A slave read at slave address 0 returns the inbound register and clears the inbound-full flag.
- R5: A slave write at slave address 1 loads the outbound register and sets the outbound-full flag, status bit 0. A host read at host address 0 returns the outbound register and clears that flag.
- R6: A slave write to the status register (slave address 2) with bit 0 equal to 0 clears the outbound-full flag. The same write with bit 0 equal to 1 leaves the flag unchanged. Status bits 3 and 1 are never changed by this write.
- R7: Status bits 7 to 4 and bit 2 are general-purpose bits. The slave writes them at slave address 2, and both sides read them: the host at host address 1 and the slave at slave address 2.
- R8: The host has no write path to the status register. A host write changes only the inbound register, bit 3 and bit 1.
- R9: When a flag is set and cleared in the same cycle, the set wins.
- R10: Slave address 3 holds the interrupt enable in bit 0 and reads back zeros in bits 7 to 1. slv_irq is high exactly when the inbound-full flag and the enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Host chip select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Host register select and command/data marker |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data: outbound register at 0, status at 1 |
| slv_cs | input | 1 | Slave chip select |
| slv_wr | input | 1 | Slave write strobe |
| slv_rd | input | 1 | Slave read strobe |
| slv_addr | input | 2 | Slave register select |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data |
| slv_irq | output | 1 | Level interrupt to the slave |

## Verification
A wrong flag becomes visible at the ports on the next clock. It shows in the status byte that either side reads and, for the inbound flag, on slv_irq once the enable is set. A command/data bit latched from the wrong source shows in the status byte read right after the host write. A lost or extra flag clear leaves the two sides disagreeing about whether a byte is pending. The model carries that disagreement forward, so every later status read exposes it until the next set or clear event.

// File: rtl/kbc_pkg.sv
// Shared constants for the host/slave mailbox.
// Assumes a byte-wide data path and a fixed status bit layout.
package kbc_pkg;
    localparam int DATA_W   = 8;
    localparam int SADDR_W  = 2;
    // Status bit positions (fixed: both sides decode them)
    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_USR0  = 2;
    localparam int ST_CMD   = 3;
    localparam int ST_USRHI = 4;
    localparam int CTL_IEN  = 0;

    typedef enum logic [SADDR_W-1:0] {
        SA_IN   = 2'd0,
        SA_OUT  = 2'd1,
        SA_STAT = 2'd2,
        SA_CTRL = 2'd3
    } slv_reg_e;
endpackage

// File: rtl/kbc_flag.sv
// Single handshake flag with a set input and a clear input.
// Assumes set has priority when both are asserted in one cycle.
module kbc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Flag update: set beats clear, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/kbc_host_if.sv
// Host side decode: turns strobes into load/clear events and muxes read data.
// Assumes read data is combinational from the addressed register.
module kbc_host_if
    import kbc_pkg::*;
(
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] out_reg_i,
    input  logic [7:0]        stat_i,
    output logic              load_in_o,
    output logic              take_out_o,
    output logic [DATA_W-1:0] rdata_o
);
    // Event decode: any write loads inbound, read at 0 drains outbound
    always_comb begin
        load_in_o  = cs_i && wr_i;
        take_out_o = cs_i && rd_i && !addr_i;
    end

    // Read mux: outbound data at 0, status at 1
    always_comb begin
        rdata_o = addr_i ? stat_i : out_reg_i;
    end
endmodule

// File: rtl/kbc_slave_if.sv
// Slave side decode for the four slave registers and read mux.
// Assumes one access per cycle; writes to the inbound address are ignored.
module kbc_slave_if
    import kbc_pkg::*;
(
    input  logic               cs_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [SADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]  in_reg_i,
    input  logic [DATA_W-1:0]  out_reg_i,
    input  logic [7:0]         stat_i,
    input  logic               ien_i,
    output logic               take_in_o,
    output logic               load_out_o,
    output logic               wr_stat_o,
    output logic               wr_ctrl_o,
    output logic [DATA_W-1:0]  rdata_o
);
    slv_reg_e sel;

    // Address decode into per-register events
    always_comb begin
        sel        = slv_reg_e'(addr_i);
        take_in_o  = cs_i && rd_i && (sel == SA_IN);
        load_out_o = cs_i && wr_i && (sel == SA_OUT);
        wr_stat_o  = cs_i && wr_i && (sel == SA_STAT);
        wr_ctrl_o  = cs_i && wr_i && (sel == SA_CTRL);
    end

    // Read mux over the four slave registers
    always_comb begin
        unique case (sel)
            SA_IN:   rdata_o = in_reg_i;
            SA_OUT:  rdata_o = out_reg_i;
            SA_STAT: rdata_o = stat_i;
            default: begin
                rdata_o          = '0;
                rdata_o[CTL_IEN] = ien_i;
            end
        endcase
    end
endmodule

// File: rtl/kbc_status.sv
// Status register: two handshake flags, the command/data marker and the
// slave-owned general-purpose bits. Assumes event inputs are one-cycle pulses.
module kbc_status
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_load_i,
    input  logic              host_cmd_i,
    input  logic              host_take_i,
    input  logic              slv_take_i,
    input  logic              slv_load_i,
    input  logic              slv_wr_stat_i,
    input  logic [DATA_W-1:0] slv_wdata_i,
    output logic [7:0]        stat_o
);
    localparam int USR_HI_W = 8 - ST_USRHI;

    logic                ibf, obf, cmd_q, usr0_q;
    logic [USR_HI_W-1:0] usr_hi_q;
    logic                obf_clr;

    // Outbound clear sources: host drain or slave writing 0 to bit 0
    always_comb begin
        obf_clr = host_take_i || (slv_wr_stat_i && !slv_wdata_i[ST_OBF]);
    end

    kbc_flag u_ibf (.clk(clk), .rst_n(rst_n), .set_i(host_load_i),
                    .clr_i(slv_take_i), .q_o(ibf));
    kbc_flag u_obf (.clk(clk), .rst_n(rst_n), .set_i(slv_load_i),
                    .clr_i(obf_clr), .q_o(obf));

    // Command/data marker captured on each host write
    always_ff @(posedge clk) begin
        if (!rst_n)           cmd_q <= 1'b0;
        else if (host_load_i) cmd_q <= host_cmd_i;
    end

    // General-purpose bits owned by the slave
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr0_q   <= 1'b0;
            usr_hi_q <= '0;
        end else if (slv_wr_stat_i) begin
            usr0_q   <= slv_wdata_i[ST_USR0];
            usr_hi_q <= slv_wdata_i[7:ST_USRHI];
        end
    end

    // Assemble the status byte
    always_comb begin
        stat_o              = '0;
        stat_o[ST_OBF]      = obf;
        stat_o[ST_IBF]      = ibf;
        stat_o[ST_USR0]     = usr0_q;
        stat_o[ST_CMD]      = cmd_q;
        stat_o[7:ST_USRHI]  = usr_hi_q;
    end
endmodule

// File: rtl/kbc_mailbox.sv
// Top of the host/slave byte mailbox: data registers, enable and interrupt.
// Assumes both buses are synchronous to clk and strobes are sampled per edge.
module kbc_mailbox
    import kbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic               host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               slv_cs,
    input  logic               slv_wr,
    input  logic               slv_rd,
    input  logic [SADDR_W-1:0] slv_addr,
    input  logic [DATA_W-1:0]  slv_wdata,
    output logic [DATA_W-1:0]  slv_rdata,
    output logic               slv_irq
);
    logic [DATA_W-1:0] in_q, out_q;
    logic [7:0]        stat_q;
    logic              ien_q;
    logic              h_load, h_take, s_take, s_load, s_wstat, s_wctrl;

    kbc_host_if u_host (
        .cs_i(host_cs), .wr_i(host_wr), .rd_i(host_rd), .addr_i(host_addr),
        .out_reg_i(out_q), .stat_i(stat_q),
        .load_in_o(h_load), .take_out_o(h_take), .rdata_o(host_rdata)
    );

    kbc_slave_if u_slave (
        .cs_i(slv_cs), .wr_i(slv_wr), .rd_i(slv_rd), .addr_i(slv_addr),
        .in_reg_i(in_q), .out_reg_i(out_q), .stat_i(stat_q), .ien_i(ien_q),
        .take_in_o(s_take), .load_out_o(s_load), .wr_stat_o(s_wstat),
        .wr_ctrl_o(s_wctrl), .rdata_o(slv_rdata)
    );

    kbc_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .host_load_i(h_load), .host_cmd_i(host_addr), .host_take_i(h_take),
        .slv_take_i(s_take), .slv_load_i(s_load), .slv_wr_stat_i(s_wstat),
        .slv_wdata_i(slv_wdata), .stat_o(stat_q)
    );

    // Inbound data register, loaded by the host
    always_ff @(posedge clk) begin
        if (!rst_n)      in_q <= '0;
        else if (h_load) in_q <= host_wdata;
    end

    // Outbound data register, loaded by the slave
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (s_load) out_q <= slv_wdata;
    end

    // Interrupt enable held in the slave control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ien_q <= 1'b0;
        else if (s_wctrl) ien_q <= slv_wdata[CTL_IEN];
    end

    // Level interrupt from inbound-full gated by enable
    always_comb begin
        slv_irq = stat_q[ST_IBF] && ien_q;
    end
endmodule

// File: rtl/kbc_mailbox_chk.sv
// Property checker for kbc_mailbox, attached by bind.
module kbc_mailbox_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_cs,
    input logic       host_wr,
    input logic       host_rd,
    input logic       host_addr,
    input logic       slv_cs,
    input logic       slv_wr,
    input logic       slv_rd,
    input logic [1:0] slv_addr,
    input logic [7:0] slv_wdata,
    input logic [7:0] stat,
    input logic       ien,
    input logic       slv_irq
);
    logic hw, hr0, sr0, sw1, sw2;
    always_comb begin
        hw  = host_cs && host_wr;
        hr0 = host_cs && host_rd && !host_addr;
        sr0 = slv_cs && slv_rd && slv_addr == 2'd0;
        sw1 = slv_cs && slv_wr && slv_addr == 2'd1;
        sw2 = slv_cs && slv_wr && slv_addr == 2'd2;
    end

    p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hw |=> stat[1]);
    p_cmd_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hw |=> stat[3] == $past(host_addr));
    p_ibf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sr0 && !hw) |=> !stat[1]);
    p_obf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sw1 |=> stat[0]);
    p_obf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hr0 && !sw1) |=> !stat[0]);
    p_obf_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw2 && slv_wdata[0] && !hr0) |=> stat[0] == $past(stat[0]));
    p_host_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw && !sw2) |=> (stat[7:4] == $past(stat[7:4])) && (stat[2] == $past(stat[2])));
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw && sr0) |=> stat[1]);
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slv_irq |-> (stat[1] && ien));
endmodule

bind kbc_mailbox kbc_mailbox_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .slv_cs(slv_cs),
    .slv_wr(slv_wr), .slv_rd(slv_rd), .slv_addr(slv_addr),
    .slv_wdata(slv_wdata), .stat(stat_q), .ien(ien_q), .slv_irq(slv_irq)
);

// File: tb/kbc_mailbox_bench.sv
module kbc_mailbox_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 0, host_wr = 0, host_rd = 0, host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       slv_cs = 0, slv_wr = 0, slv_rd = 0;
    logic [1:0] slv_addr = 0;
    logic [7:0] slv_wdata = 0, slv_rdata;
    logic       slv_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_in = 0, m_out = 0, m_stat = 0;
    logic       m_ien = 0;

    always #4 clk = ~clk;

    kbc_mailbox u_kbc_mailbox (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_host(input logic a);
        return a ? m_stat : m_out;
    endfunction

    function automatic logic [7:0] exp_slv(input logic [1:0] a);
        case (a)
            2'd0: return m_in;
            2'd1: return m_out;
            2'd2: return m_stat;
            default: return {7'b0, m_ien};
        endcase
    endfunction

    // model update from the strobes sampled at the edge
    task automatic model_step();
        logic hw, hr0, sr0, sw1, sw2, sw3;
        logic [7:0] n;
        hw  = host_cs && host_wr;
        hr0 = host_cs && host_rd && !host_addr;
        sr0 = slv_cs && slv_rd && slv_addr == 2'd0;
        sw1 = slv_cs && slv_wr && slv_addr == 2'd1;
        sw2 = slv_cs && slv_wr && slv_addr == 2'd2;
        sw3 = slv_cs && slv_wr && slv_addr == 2'd3;
        n = m_stat;
        if (hw) begin m_in = host_wdata; n[3] = host_addr; end
        n[1] = hw | (m_stat[1] & ~sr0);
        n[0] = sw1 | (m_stat[0] & ~(hr0 | (sw2 & ~slv_wdata[0])));
        if (sw2) begin n[7:4] = slv_wdata[7:4]; n[2] = slv_wdata[2]; end
        if (sw1) m_out = slv_wdata;
        if (sw3) m_ien = slv_wdata[0];
        m_stat = n;
    endtask

    // one bus cycle: drive, check reads, clock, update model
    task automatic step(input logic hcs, hwr, hrd, ha, input logic [7:0] hd,
                        input logic scs, swr, srd, input logic [1:0] sa,
                        input logic [7:0] sd);
        @(negedge clk);
        host_cs = hcs; host_wr = hwr; host_rd = hrd; host_addr = ha; host_wdata = hd;
        slv_cs = scs; slv_wr = swr; slv_rd = srd; slv_addr = sa; slv_wdata = sd;
        #1;
        if (hcs && hrd) check(ha ? "R7 host status" : "R5 host outbound", host_rdata, exp_host(ha));
        if (scs && srd) begin
            case (sa)
                2'd0: check("R4 slave inbound", slv_rdata, exp_slv(sa));
                2'd1: check("R5 slave outbound", slv_rdata, exp_slv(sa));
                2'd2: check("R6 slave status", slv_rdata, exp_slv(sa));
                default: check("R10 slave control", slv_rdata, exp_slv(sa));
            endcase
        end
        check("R10 irq", {7'b0, slv_irq}, {7'b0, m_stat[1] & m_ien});
        @(posedge clk);
        model_step();
    endtask

    task automatic idle();
        step(0,0,0,0,8'h00, 0,0,0,2'd0,8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        // R1 reset state
        #1;
        host_addr = 0; slv_addr = 0; #1; check("R1 host 0", host_rdata, 8'h00);
        check("R1 slave 0", slv_rdata, 8'h00);
        host_addr = 1; slv_addr = 2; #1; check("R1 status", host_rdata, 8'h00);
        check("R1 slave status", slv_rdata, 8'h00);
        slv_addr = 3; #1; check("R1 control", slv_rdata, 8'h00);
        check("R1 irq", {7'b0, slv_irq}, 8'h00);
        @(negedge clk); rst_n = 1;

        // R2/R3: host command write at address 1, data write at 0
        step(1,1,0,1,8'hA5, 0,0,0,2'd0,8'h00);
        step(0,0,0,0,8'h00, 1,0,1,2'd2,8'h00);          // R2/R3 status 0x0A
        check("R3 cmd bit set", m_stat, 8'h0A);
        step(1,0,1,1,8'h00, 1,0,1,2'd0,8'h00);          // R4 read inbound A5, clears IBF
        step(1,1,0,0,8'h3C, 0,0,0,2'd0,8'h00);
        step(1,0,1,1,8'h00, 1,0,1,2'd0,8'h00);          // R3 data marker 0, R2 3C
        // R6: write 1 to OBF has no effect, 0 clears; user bits R7
        step(0,0,0,0,8'h00, 1,1,0,2'd1,8'h77);          // R5 set OBF
        step(0,0,0,0,8'h00, 1,1,0,2'd2,8'hFF);          // R6 write 1 keeps OBF
        step(1,0,1,1,8'h00, 1,0,1,2'd2,8'h00);          // R6/R7 status F5
        step(1,1,0,1,8'h11, 0,0,0,2'd0,8'h00);          // R8 host write leaves user bits
        step(1,0,1,1,8'h00, 0,0,0,2'd0,8'h00);
        step(0,0,0,0,8'h00, 1,1,0,2'd2,8'h00);          // R6 write 0 clears OBF
        step(1,0,1,1,8'h00, 1,0,1,2'd0,8'h00);
        // R9 set wins: host write with slave inbound read
        step(1,1,0,0,8'h5A, 1,0,1,2'd0,8'h00);
        step(1,0,1,1,8'h00, 0,0,0,2'd0,8'h00);          // R9 IBF still 1
        step(0,0,0,0,8'h00, 1,1,0,2'd1,8'h99);
        step(1,0,1,0,8'h00, 1,1,0,2'd1,8'h42);          // R9 OBF set wins over host drain
        step(1,0,1,1,8'h00, 1,0,1,2'd1,8'h00);
        // R10 enable interrupt
        step(0,0,0,0,8'h00, 1,1,0,2'd3,8'hFF);
        step(0,0,0,0,8'h00, 1,0,1,2'd3,8'h00);
        idle();
        // random phase
        for (int i = 0; i < 3000; i++) begin
            int hop, sop;
            logic [7:0] sd;
            hop = $urandom % 4;
            sop = $urandom % 4;
            sd  = 8'($urandom);
            if (($urandom % 2) == 0) sd[0] = 1'b1;
            step(hop != 0, hop == 1, hop >= 2, 1'($urandom), 8'($urandom),
                 sop != 0, sop == 1, sop >= 2, 2'($urandom), sd);
        end
        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule